// File: doc/BRIEF.md
# Transmit Interrupt Status Register

This block holds eight transmit-side interrupt flags for the host interface of a low-power radio. Four flags are set directly by single-cycle strobes from the transmit datapath: transmission complete, encryption finished, first preamble sample on air, and frame parse error. The other four come from checks made inside the block. A length check runs when a transmission starts. An overflow check catches a host write to a TX buffer that is not empty. One counter tracks unacknowledged retries and another tracks CSMA busy results. Each counter compares its count with a limit set by the host.

The host reads the whole byte in one access, and that read clears every flag. The host may also write the register directly. A level-sensitive interrupt request is the OR of all flags, each gated by its own enable bit. The block is placed between the transmit engine and the host-side serial interface logic. That interface logic turns a register access into a one-cycle read or write strobe.

Top module: `txint_status`

## Requirements
- R1: After reset, rd_data is 8'h00 and irq is 0.
- R2: The flags sit at these bit positions: done 7, encryption 6, medium access 5, no-ack failure 4, CSMA failure 3, size error 2, overflow 1, parse error 0. A strobe on ev_done, ev_crypt_done, ev_air_start or ev_parse_err sets its bit, and rd_data shows the bit on the cycle after the strobe.
- R3: A flag that is set stays set until the host reads or writes the register.
- R4: During a cycle with host_rd high, rd_data shows the flags as they were before the clear. On the next cycle every flag is 0, except a flag that was set again in the read cycle.
- R5: If a set condition arrives in the same cycle as a read-clear, the set wins and that flag is 1 afterwards.
- R6: A cycle with host_wr high loads wr_data into the flags. The write takes priority over a read in the same cycle. Set conditions in that cycle are ORed on top of the written value.
- R7: When tx_start is high and tx_len is 0 or greater than MAX_LEN (default 127), bit 2 is set. A tx_len in the range 1 to MAX_LEN sets nothing.
- R8: When txbuf_wr is high while txbuf_empty is 0, bit 1 is set. When txbuf_empty is 1, the write sets nothing.
- R9: With ack_req high, the ack_timeout strobes are counted. The strobe numbered retry_limit+1 sets bit 4, and the count then restarts. A timeout strobe with ack_req low is ignored.
- R10: With csma_en high, the cca_busy strobes are counted. The strobe numbered max(busy_limit,1) sets bit 3, and the count restarts. A busy strobe with csma_en low is ignored.
- R11: tx_start clears both the retry count and the busy count. ack_rcvd clears the retry count, and csma_ok clears the busy count. Any of these clears takes priority over a strobe in the same cycle.
- R12: irq is high exactly when some flag is 1 and its bit in irq_en is 1. It falls once those flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_done | input | 1 | Transmission complete strobe |
| ev_crypt_done | input | 1 | Encryption finished strobe |
| ev_air_start | input | 1 | First preamble sample sent strobe |
| ev_parse_err | input | 1 | Frame parse failure strobe |
| tx_start | input | 1 | Host started a transmission |
| tx_len | input | 8 | Length byte at the head of the TX buffer |
| txbuf_wr | input | 1 | Host write to the TX buffer |
| txbuf_empty | input | 1 | TX buffer empty status |
| ack_req | input | 1 | Frame being sent asks for an acknowledgement |
| ack_timeout | input | 1 | Acknowledgement wait expired without an ACK |
| ack_rcvd | input | 1 | Acknowledgement received |
| retry_limit | input | 4 | Maximum retransmissions |
| csma_en | input | 1 | CSMA-CA enabled |
| cca_busy | input | 1 | Channel assessment found the channel busy |
| csma_ok | input | 1 | Channel access granted |
| busy_limit | input | 3 | Busy results allowed before failure |
| host_rd | input | 1 | Register read strobe (clears flags) |
| host_wr | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| irq_en | input | 8 | Per-flag interrupt enable |
| rd_data | output | 8 | Current flag byte |
| irq | output | 1 | Level interrupt request |

## Verification
The event flags are first set one at a time, and then several are stacked up. Setting them separately confirms that each strobe lands on its own bit. Stacking them shows that the flags hold across idle cycles. Reads are then combined with sets, and writes with reads and sets, in the same cycle. These collisions separate a design where the clear wins from one where the set wins, and they also test the write-over-read priority. For the two counters, the bench steps each limit through 0 and mid-range values and sends strobes both with the enable off and with resets partway through. This catches off-by-one thresholds, ignored enables and counts that are not cleared. Lengths of 0, 1, MAX_LEN and MAX_LEN+1 locate the edges of the size check.

// File: rtl/txint_pkg.sv
package txint_pkg;

    localparam int FLAG_W = 8;

    // bit positions of the flag byte
    localparam int B_DONE  = 7;
    localparam int B_CRYPT = 6;
    localparam int B_AIR   = 5;
    localparam int B_NOACK = 4;
    localparam int B_CSMA  = 3;
    localparam int B_SIZE  = 2;
    localparam int B_OVF   = 1;
    localparam int B_PARSE = 0;

    typedef logic [FLAG_W-1:0] flags_t;

    typedef struct packed {
        flags_t flags;
    } stat_state_t;

endpackage

// File: rtl/txint_len_check.sv
module txint_len_check #(
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 127
) (
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             bad
);
    localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);

    logic is_zero;
    logic too_big;

    always_comb begin
        is_zero = (len == '0);
        too_big = (len > MAX_V);
        bad     = start && (is_zero || too_big);
    end
endmodule

// File: rtl/txint_limit_cnt.sv
module txint_limit_cnt #(
    parameter int LIM_W  = 4,
    parameter bit STRICT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rewind,
    input  logic             gate,
    input  logic             step,
    input  logic [LIM_W-1:0] limit,
    output logic             hit
);
    localparam int CNT_W = LIM_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] lim_ext;
    logic             reached;

    assign nxt     = st_q.cnt + CNT_W'(1);
    assign lim_ext = {1'b0, limit};

    generate
        if (STRICT) begin : g_strict
            // the event numbered limit+1 is the failing one
            assign reached = (nxt > lim_ext);
        end else begin : g_inclusive
            // the event numbered limit (at least one) is the failing one
            assign reached = (nxt >= lim_ext);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (clr || rewind) begin
            st_d.cnt = '0;
        end else if (gate && step) begin
            if (reached) begin
                hit      = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/txint_status.sv
module txint_status
    import txint_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 127,
    parameter int RETRY_W = 4,
    parameter int BUSY_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_done,
    input  logic               ev_crypt_done,
    input  logic               ev_air_start,
    input  logic               ev_parse_err,
    input  logic               tx_start,
    input  logic [LEN_W-1:0]   tx_len,
    input  logic               txbuf_wr,
    input  logic               txbuf_empty,
    input  logic               ack_req,
    input  logic               ack_timeout,
    input  logic               ack_rcvd,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               csma_en,
    input  logic               cca_busy,
    input  logic               csma_ok,
    input  logic [BUSY_W-1:0]  busy_limit,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [FLAG_W-1:0]  wr_data,
    input  logic [FLAG_W-1:0]  irq_en,
    output logic [FLAG_W-1:0]  rd_data,
    output logic               irq
);
    stat_state_t st_d, st_q;
    flags_t      set_vec;
    flags_t      base;
    logic        size_bad;
    logic        noack_hit;
    logic        busy_hit;

    txint_len_check #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) u_len (
        .start (tx_start),
        .len   (tx_len),
        .bad   (size_bad)
    );

    txint_limit_cnt #(
        .LIM_W  (RETRY_W),
        .STRICT (1'b1)
    ) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_start),
        .rewind (ack_rcvd),
        .gate   (ack_req),
        .step   (ack_timeout),
        .limit  (retry_limit),
        .hit    (noack_hit)
    );

    txint_limit_cnt #(
        .LIM_W  (BUSY_W),
        .STRICT (1'b0)
    ) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_start),
        .rewind (csma_ok),
        .gate   (csma_en),
        .step   (cca_busy),
        .limit  (busy_limit),
        .hit    (busy_hit)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[B_DONE]  = ev_done;
        set_vec[B_CRYPT] = ev_crypt_done;
        set_vec[B_AIR]   = ev_air_start;
        set_vec[B_NOACK] = noack_hit;
        set_vec[B_CSMA]  = busy_hit;
        set_vec[B_SIZE]  = size_bad;
        set_vec[B_OVF]   = txbuf_wr && !txbuf_empty;
        set_vec[B_PARSE] = ev_parse_err;

        // write beats read-clear; hardware sets beat both
        if (host_wr)      base = wr_data;
        else if (host_rd) base = '0;
        else              base = st_q.flags;

        st_d       = st_q;
        st_d.flags = base | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.flags;
    assign irq     = |(st_q.flags & irq_en);
endmodule

module txint_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_done,
    input logic       tx_start,
    input logic [7:0] tx_len,
    input logic       txbuf_wr,
    input logic       txbuf_empty,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] wr_data,
    input logic [7:0] set_vec,
    input logic [7:0] rd_data
);
    // R2
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> rd_data[7]);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd && !host_wr) |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> ((rd_data & ~$past(set_vec)) == 8'h00));

    // R6
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ((rd_data & ~$past(set_vec)) == ($past(wr_data) & ~$past(set_vec))));

    // R7
    size_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && (tx_len == 8'd0)) |=> rd_data[2]);

    // R8
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txbuf_wr && !txbuf_empty) |=> rd_data[1]);
endmodule

bind txint_status txint_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_done     (ev_done),
    .tx_start    (tx_start),
    .tx_len      (tx_len),
    .txbuf_wr    (txbuf_wr),
    .txbuf_empty (txbuf_empty),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .wr_data     (wr_data),
    .set_vec     (set_vec),
    .rd_data     (rd_data)
);

// File: tb/sim_txint_status.sv
module sim_txint_status;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 127;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_done = 0, ev_crypt_done = 0, ev_air_start = 0, ev_parse_err = 0;
    logic       tx_start = 0;
    logic [7:0] tx_len = 8'd10;
    logic       txbuf_wr = 0, txbuf_empty = 1;
    logic       ack_req = 0, ack_timeout = 0, ack_rcvd = 0;
    logic [3:0] retry_limit = 4'd0;
    logic       csma_en = 0, cca_busy = 0, csma_ok = 0;
    logic [2:0] busy_limit = 3'd0;
    logic       host_rd = 0, host_wr = 0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] irq_en = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txint_status u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_done(ev_done), .ev_crypt_done(ev_crypt_done),
        .ev_air_start(ev_air_start), .ev_parse_err(ev_parse_err),
        .tx_start(tx_start), .tx_len(tx_len),
        .txbuf_wr(txbuf_wr), .txbuf_empty(txbuf_empty),
        .ack_req(ack_req), .ack_timeout(ack_timeout), .ack_rcvd(ack_rcvd),
        .retry_limit(retry_limit),
        .csma_en(csma_en), .cca_busy(cca_busy), .csma_ok(csma_ok),
        .busy_limit(busy_limit),
        .host_rd(host_rd), .host_wr(host_wr), .wr_data(wr_data),
        .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference, compared before each update
    logic [7:0] m_flags = 8'h00;
    int         m_rc = 0;
    int         m_bc = 0;

    always @(posedge clk) begin
        logic [7:0] sv;
        logic [7:0] nb;
        if (!rst_n) begin
            m_flags = 8'h00; m_rc = 0; m_bc = 0;
        end else begin
            chk("R3 model flags", rd_data, m_flags);
            chk("R12 model irq", {7'd0, irq}, {7'd0, |(m_flags & irq_en)});
            sv = 8'h00;
            if (ev_done)       sv[7] = 1'b1;
            if (ev_crypt_done) sv[6] = 1'b1;
            if (ev_air_start)  sv[5] = 1'b1;
            if (ev_parse_err)  sv[0] = 1'b1;
            if (tx_start && (tx_len == 0 || int'(tx_len) > MAXL)) sv[2] = 1'b1;
            if (txbuf_wr && !txbuf_empty) sv[1] = 1'b1;
            if (tx_start || ack_rcvd) m_rc = 0;
            else if (ack_req && ack_timeout) begin
                if (m_rc + 1 > int'(retry_limit)) begin sv[4] = 1'b1; m_rc = 0; end
                else m_rc = m_rc + 1;
            end
            if (tx_start || csma_ok) m_bc = 0;
            else if (csma_en && cca_busy) begin
                if (m_bc + 1 >= int'(busy_limit)) begin sv[3] = 1'b1; m_bc = 0; end
                else m_bc = m_bc + 1;
            end
            nb = host_wr ? wr_data : (host_rd ? 8'h00 : m_flags);
            m_flags = nb | sv;
        end
    end

    task automatic cyc();
        @(negedge clk);
        ev_done = 0; ev_crypt_done = 0; ev_air_start = 0; ev_parse_err = 0;
        tx_start = 0; txbuf_wr = 0; ack_timeout = 0; ack_rcvd = 0;
        cca_busy = 0; csma_ok = 0; host_rd = 0; host_wr = 0;
    endtask

    task automatic clear_all();
        host_rd = 1; cyc();
    endtask

    task automatic timeouts(input int n);
        for (int i = 0; i < n; i++) begin ack_timeout = 1; cyc(); end
    endtask

    task automatic busies(input int n);
        for (int i = 0; i < n; i++) begin cca_busy = 1; cyc(); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset flags", rd_data, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1;
        cyc();
        chk("R1 after reset", rd_data, 8'h00);

        // R2 event strobes, one after another
        ev_done = 1; cyc();       chk("R2 done bit", rd_data, 8'h80);
        ev_crypt_done = 1; cyc(); chk("R2 crypt bit", rd_data, 8'hC0);
        ev_air_start = 1; cyc();  chk("R2 air bit", rd_data, 8'hE0);
        ev_parse_err = 1; cyc();  chk("R2 parse bit", rd_data, 8'hE1);
        cyc(); cyc(); cyc();      chk("R3 flags hold", rd_data, 8'hE1);

        // R4 read returns old value, then clears
        host_rd = 1;
        chk("R4 value at read", rd_data, 8'hE1);
        cyc();
        chk("R4 cleared", rd_data, 8'h00);

        // R5 set beats clear
        ev_air_start = 1; cyc();
        host_rd = 1; ev_done = 1; cyc();
        chk("R5 set wins", rd_data, 8'h80);
        clear_all();

        // R6 write, and write over read with a set
        host_wr = 1; wr_data = 8'h5A; cyc();
        chk("R6 write load", rd_data, 8'h5A);
        host_wr = 1; host_rd = 1; wr_data = 8'h0F; ev_air_start = 1; cyc();
        chk("R6 write beats read", rd_data, 8'h2F);
        clear_all();

        // R7 length edges
        tx_len = 8'd0;   tx_start = 1; cyc(); chk("R7 len 0", rd_data, 8'h04);
        clear_all();
        tx_len = 8'd127; tx_start = 1; cyc(); chk("R7 len max", rd_data, 8'h00);
        tx_len = 8'd128; tx_start = 1; cyc(); chk("R7 len max+1", rd_data, 8'h04);
        clear_all();
        tx_len = 8'd1;   tx_start = 1; cyc(); chk("R7 len 1", rd_data, 8'h00);
        tx_len = 8'd10;

        // R8 overflow
        txbuf_empty = 1; txbuf_wr = 1; cyc(); chk("R8 empty write", rd_data, 8'h00);
        txbuf_empty = 0; txbuf_wr = 1; cyc(); chk("R8 overflow", rd_data, 8'h02);
        txbuf_empty = 1;
        clear_all();

        // R9 retry exhaustion
        retry_limit = 4'd2; ack_req = 1;
        tx_start = 1; cyc();
        timeouts(2); chk("R9 below limit", rd_data, 8'h00);
        timeouts(1); chk("R9 limit reached", rd_data, 8'h10);
        clear_all();
        ack_req = 0;
        timeouts(5); chk("R9 no ack request", rd_data, 8'h00);
        ack_req = 1;
        timeouts(2); ack_rcvd = 1; cyc();
        timeouts(2); chk("R11 ack clears count", rd_data, 8'h00);
        timeouts(1); chk("R11 count after ack", rd_data, 8'h10);
        clear_all();
        timeouts(2); tx_start = 1; cyc();
        timeouts(2); chk("R11 start clears retry", rd_data, 8'h00);
        timeouts(1); chk("R9 after restart", rd_data, 8'h10);
        clear_all();
        retry_limit = 4'd0;
        timeouts(1); chk("R9 zero limit", rd_data, 8'h10);
        clear_all();
        ack_req = 0;

        // R10 CSMA busy exhaustion
        busy_limit = 3'd3; csma_en = 1;
        tx_start = 1; cyc();
        busies(2); chk("R10 below limit", rd_data, 8'h00);
        busies(1); chk("R10 limit reached", rd_data, 8'h08);
        clear_all();
        csma_en = 0;
        busies(4); chk("R10 csma off", rd_data, 8'h00);
        csma_en = 1;
        busies(2); csma_ok = 1; cyc();
        busies(2); chk("R11 grant clears busy", rd_data, 8'h00);
        tx_start = 1; cyc();
        busies(2); chk("R11 start clears busy", rd_data, 8'h00);
        busies(1); chk("R10 after restart", rd_data, 8'h08);
        clear_all();
        busy_limit = 3'd0;
        busies(1); chk("R10 zero limit", rd_data, 8'h08);
        clear_all();
        csma_en = 0;

        // R12 interrupt masking
        ev_done = 1; irq_en = 8'h7F; cyc();
        chk("R12 masked", {7'd0, irq}, 8'h00);
        irq_en = 8'h80; cyc();
        chk("R12 enabled", {7'd0, irq}, 8'h01);
        clear_all();
        chk("R12 falls on clear", {7'd0, irq}, 8'h00);

        cyc(); cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule